// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the control strobes of a classic 8-bit microcontroller external memory bus from the oscillator clock. A machine cycle has six states, S0 to S5. Each state lasts two oscillator clocks in normal timing and one clock in double-speed timing, so a machine cycle is 12 or 6 clocks. In every cycle the block drives an address-latch pulse (`ale`), the program-store read strobe (`psen_n`) and the data read and write strobes (`rd_n`, `wr_n`).

Each cycle is either a code-fetch cycle or, when the CPU has handed over a data-transfer request, an external data cycle. For a code fetch, the block checks the external-access pin and the program counter against the top of internal program memory. It then decides whether the fetch goes off-chip, which sets whether the read strobe pulses and whether the latch pulse may be silenced. A raw reset pin is qualified over two machine cycles before the block asserts its own reset output, which the core uses as its reset.

The data-transfer request is a valid/ready handshake. `movx_ready` is high for exactly one clock, the last clock of each machine cycle. A request is taken only on a clock where `movx_valid` and `movx_ready` are both high. The requester keeps `movx_valid` and `movx_write` steady until that clock. Asserting `movx_valid` in any other clock has no effect.

Top module: `bus_strobe_seq`

## Requirements
- R1: In code-fetch cycles `ale` rises in S0 and S3 and stays high for one state, so consecutive rises are 6 clocks apart in normal timing (`x2_en`=0) and 3 clocks apart in double-speed timing (`x2_en`=1).
- R2: In an external code-fetch cycle `psen_n` goes low twice per machine cycle, once over S1–S2 and once over S4–S5. It is high whenever `ale` is high.
- R3: In an internal code-fetch cycle `psen_n` stays high for the whole machine cycle.
- R4: A code fetch is external when the effective external-access level is 0, or when `pc` is greater than `INT_TOP` (default 3FFFh). It is internal otherwise, so `pc`=3FFFh is internal and 4000h is external. The source is sampled on the last clock of the previous cycle.
- R5: The machine cycle after an accepted request is a data cycle. `ale` pulses only in S0, so the S3 pulse is dropped. `psen_n` stays high, so both of its pulses are dropped. For S1–S5, `rd_n` is low if `movx_write`=0, or `wr_n` is low if `movx_write`=1. `rd_n` and `wr_n` are never low together.
- R6: When `ale_dis`=1, `ale` stays low in internal code-fetch cycles. External code-fetch cycles and data cycles keep their normal `ale` pulses.
- R7: `movx_ready` is high only on the last clock of each machine cycle, and for one clock at a time. A `movx_valid` pulse that does not overlap `movx_ready` does not change the following cycles.
- R8: `sys_rst` rises on the 24th consecutive rising edge at which `rst_in` is high (the 12th in double-speed timing), and no earlier. It falls on the first rising edge at which `rst_in` is low.
- R9: While `sys_rst` is high, `ale` is low and `psen_n`, `rd_n` and `wr_n` are high. The first clock after `sys_rst` falls is S0 of a new cycle, with `ale` high.
- R10: With `LOCK_EA`=1, the external-access level is captured while `sys_rst` is high, and later changes of `ea_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset pin, active high, qualified internally |
| x2_en | input | 1 | 1 selects double-speed timing (one clock per state) |
| ea_in | input | 1 | External-access level; 0 forces every fetch off-chip |
| ale_dis | input | 1 | 1 silences `ale` during internal code fetches |
| pc | input | PC_W | Program counter of the next fetch |
| movx_valid | input | 1 | Data-transfer request valid |
| movx_ready | output | 1 | Request accepted on this clock if valid |
| movx_write | input | 1 | Direction of the request: 1 write, 0 read |
| ale | output | 1 | Address-latch pulse, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| sys_rst | output | 1 | Qualified reset for the core, active high |

## Verification
The state counter, the phase bit and the latched cycle descriptor together set every strobe. A wrong state or phase appears within one machine cycle as a shifted `ale` rise, a changed pulse spacing or a `movx_ready` off the last clock. A wrong descriptor shows in the very next cycle as a wrong count of `ale` or `psen_n` pulses, or as a data strobe on the wrong pin. A faulty reset count shows as `sys_rst` rising one edge early or late, so the bench samples the clock before and the clock of the expected rise.

// File: rtl/strb_pkg.sv
`timescale 1ns/1ps
package strb_pkg;
  // Everything the strobe decoder needs to know about one machine cycle,
  // captured once at the cycle boundary.
  typedef struct packed {
    logic data;     // external data cycle
    logic wr;       // data cycle direction: 1 = write
    logic ext;      // code fetch goes off-chip
    logic ale_off;  // latch pulse silencing requested for internal fetch
  } cyc_t;
endpackage

// File: rtl/strb_rst_qual.sv
`timescale 1ns/1ps
module strb_rst_qual #(
  parameter int unsigned QUAL_MC = 2,
  parameter int unsigned STATES  = 6
) (
  input  logic clk,
  input  logic rst_in,
  input  logic x2,
  output logic sys_rst
);
  localparam int unsigned LIM_N = QUAL_MC * STATES * 2;
  localparam int unsigned LIM_X = QUAL_MC * STATES;
  localparam int unsigned CW    = $clog2(LIM_N + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = x2 ? CW'(LIM_X) : CW'(LIM_N);

  always_ff @(posedge clk) begin
    if (!rst_in) begin
      cnt     <= '0;
      sys_rst <= 1'b0;
    end else begin
      if (cnt < lim) cnt <= cnt + 1'b1;
      if (cnt >= lim - 1'b1) sys_rst <= 1'b1;
    end
  end
endmodule

// File: rtl/strb_timebase.sv
`timescale 1ns/1ps
module strb_timebase #(
  parameter int unsigned STATES = 6,
  localparam int unsigned ST_W  = $clog2(STATES)
) (
  input  logic            clk,
  input  logic            sys_rst,
  input  logic            x2,
  output logic [ST_W-1:0] st,
  output logic            last
);
  logic ph;
  logic tick;

  assign tick = x2 | ph;
  assign last = tick && (st == ST_W'(STATES - 1));

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      ph <= 1'b0;
      st <= '0;
    end else begin
      ph <= x2 ? 1'b0 : ~ph;
      if (tick) st <= (st == ST_W'(STATES - 1)) ? '0 : st + 1'b1;
    end
  end
endmodule

// File: rtl/strb_cycle_ctl.sv
`timescale 1ns/1ps
module strb_cycle_ctl
  import strb_pkg::*;
#(
  parameter int unsigned   PC_W    = 16,
  parameter logic [PC_W-1:0] INT_TOP = 16'h3FFF,
  parameter bit            LOCK_EA = 1'b0
) (
  input  logic            clk,
  input  logic            sys_rst,
  input  logic            last,
  input  logic            ea_in,
  input  logic            ale_dis,
  input  logic [PC_W-1:0] pc,
  input  logic            movx_valid,
  input  logic            movx_write,
  output logic            movx_ready,
  output cyc_t            cyc
);
  logic ea_eff;
  logic fetch_ext;

  generate
    if (LOCK_EA) begin : g_lock
      logic ea_q;
      always_ff @(posedge clk) begin
        if (sys_rst) ea_q <= ea_in;
      end
      assign ea_eff = ea_q;
    end else begin : g_live
      assign ea_eff = ea_in;
    end
  endgenerate

  assign fetch_ext  = !ea_eff || (pc > INT_TOP);
  assign movx_ready = last && !sys_rst;

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      cyc <= '{data: 1'b0, wr: 1'b0, ext: fetch_ext, ale_off: ale_dis};
    end else if (last) begin
      cyc <= '{data: movx_valid, wr: movx_valid & movx_write,
               ext: fetch_ext, ale_off: ale_dis};
    end
  end
endmodule

// File: rtl/strb_decode.sv
`timescale 1ns/1ps
module strb_decode
  import strb_pkg::*;
#(
  parameter int unsigned STATES = 6,
  localparam int unsigned ST_W  = $clog2(STATES),
  localparam int unsigned ALE_B = STATES / 2
) (
  input  logic            sys_rst,
  input  logic [ST_W-1:0] st,
  input  cyc_t            cyc,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n
);
  logic at_a, at_b, code_ale, data_win;

  assign at_a     = (st == '0);
  assign at_b     = (st == ST_W'(ALE_B));
  assign code_ale = cyc.ext || !cyc.ale_off;
  assign data_win = !sys_rst && cyc.data && !at_a;

  always_comb begin
    ale    = !sys_rst && ((at_a && (cyc.data || code_ale)) ||
                          (at_b && !cyc.data && code_ale));
    psen_n = !(!sys_rst && !cyc.data && cyc.ext && !at_a && !at_b);
    rd_n   = !(data_win && !cyc.wr);
    wr_n   = !(data_win && cyc.wr);
  end
endmodule

// File: rtl/bus_strobe_seq.sv
`timescale 1ns/1ps
module bus_strobe_seq
  import strb_pkg::*;
#(
  parameter int unsigned     PC_W    = 16,
  parameter logic [PC_W-1:0] INT_TOP = 16'h3FFF,
  parameter bit              LOCK_EA = 1'b0,
  parameter int unsigned     STATES  = 6,
  parameter int unsigned     QUAL_MC = 2
) (
  input  logic            clk,
  input  logic            rst_in,
  input  logic            x2_en,
  input  logic            ea_in,
  input  logic            ale_dis,
  input  logic [PC_W-1:0] pc,
  input  logic            movx_valid,
  output logic            movx_ready,
  input  logic            movx_write,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            sys_rst
);
  localparam int unsigned ST_W = $clog2(STATES);

  logic [ST_W-1:0] st;
  logic            last;
  cyc_t            cyc;

  strb_rst_qual #(.QUAL_MC(QUAL_MC), .STATES(STATES)) u_qual (
    .clk(clk), .rst_in(rst_in), .x2(x2_en), .sys_rst(sys_rst)
  );

  strb_timebase #(.STATES(STATES)) u_tb (
    .clk(clk), .sys_rst(sys_rst), .x2(x2_en), .st(st), .last(last)
  );

  strb_cycle_ctl #(.PC_W(PC_W), .INT_TOP(INT_TOP), .LOCK_EA(LOCK_EA)) u_ctl (
    .clk(clk), .sys_rst(sys_rst), .last(last), .ea_in(ea_in),
    .ale_dis(ale_dis), .pc(pc), .movx_valid(movx_valid),
    .movx_write(movx_write), .movx_ready(movx_ready), .cyc(cyc)
  );

  strb_decode #(.STATES(STATES)) u_dec (
    .sys_rst(sys_rst), .st(st), .cyc(cyc),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
  );
endmodule

// File: rtl/bus_strobe_seq_chk.sv
`timescale 1ns/1ps
module bus_strobe_seq_chk (
  input logic clk,
  input logic rst_in,
  input logic sys_rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic movx_ready
);
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (sys_rst) armed <= 1'b1;
  end

  // R1
  ale_one_state_chk: assert property (@(posedge clk) disable iff (!armed || sys_rst)
    (ale && $past(ale)) |=> !ale);

  // R2
  ale_psen_apart_chk: assert property (@(posedge clk) disable iff (!armed)
    ale |-> psen_n);

  // R5
  data_strobe_excl_chk: assert property (@(posedge clk) disable iff (!armed)
    !(!rd_n && !wr_n));

  // R5
  data_no_psen_chk: assert property (@(posedge clk) disable iff (!armed)
    (!rd_n || !wr_n) |-> psen_n);

  // R7
  ready_single_chk: assert property (@(posedge clk) disable iff (!armed || sys_rst)
    movx_ready |=> !movx_ready);

  // R8
  rst_release_chk: assert property (@(posedge clk) disable iff (!armed)
    !rst_in |=> !sys_rst);

  // R8
  rst_rise_src_chk: assert property (@(posedge clk) disable iff (!armed)
    $rose(sys_rst) |-> $past(rst_in));

  // R9
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
    sys_rst |-> (!ale && psen_n && rd_n && wr_n && !movx_ready));
endmodule

bind bus_strobe_seq bus_strobe_seq_chk u_chk (
  .clk(clk), .rst_in(rst_in), .sys_rst(sys_rst), .ale(ale),
  .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .movx_ready(movx_ready)
);

// File: tb/bus_strobe_seq_bench.sv
`timescale 1ns/1ps
module bus_strobe_seq_bench;
  logic        clk = 1'b0;
  logic        rst_in = 1'b0;
  logic        x2_en = 1'b0;
  logic        ea_in = 1'b0;
  logic        ale_dis = 1'b0;
  logic [15:0] pc = 16'h0000;
  logic        movx_valid = 1'b0;
  logic        movx_write = 1'b0;
  logic        movx_ready, ale, psen_n, rd_n, wr_n, sys_rst;
  logic        l_ready, l_ale, l_psen_n, l_rd_n, l_wr_n, l_sys_rst;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bus_strobe_seq u_bus_strobe_seq (
    .clk(clk), .rst_in(rst_in), .x2_en(x2_en), .ea_in(ea_in),
    .ale_dis(ale_dis), .pc(pc), .movx_valid(movx_valid),
    .movx_ready(movx_ready), .movx_write(movx_write), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .sys_rst(sys_rst)
  );

  // Second instance with the external-access level locked at reset (R10)
  bus_strobe_seq #(.LOCK_EA(1'b1)) u_lock (
    .clk(clk), .rst_in(rst_in), .x2_en(x2_en), .ea_in(ea_in),
    .ale_dis(ale_dis), .pc(pc), .movx_valid(1'b0),
    .movx_ready(l_ready), .movx_write(1'b0), .ale(l_ale),
    .psen_n(l_psen_n), .rd_n(l_rd_n), .wr_n(l_wr_n), .sys_rst(l_sys_rst)
  );

  typedef struct packed {
    logic        x2;
    logic        ea;
    logic        aoff;
    logic [15:0] pc;
    logic        mv;
    logic        wr;
    logic [1:0]  e_ale;
    logic [1:0]  e_psen;
    logic [2:0]  e_rd;   // states with rd_n low
    logic [2:0]  e_wr;   // states with wr_n low
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd2, 2'd2, 3'd0, 3'd0}, // R4 EA low ext, R2
    '{1'b0, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b0, 2'd2, 2'd0, 3'd0, 3'd0}, // R3 internal
    '{1'b0, 1'b1, 1'b0, 16'h3FFF, 1'b0, 1'b0, 2'd2, 2'd0, 3'd0, 3'd0}, // R4 top internal
    '{1'b0, 1'b1, 1'b0, 16'h4000, 1'b0, 1'b0, 2'd2, 2'd2, 3'd0, 3'd0}, // R4 above top
    '{1'b0, 1'b1, 1'b1, 16'h0100, 1'b0, 1'b0, 2'd0, 2'd0, 3'd0, 3'd0}, // R6 silenced
    '{1'b0, 1'b0, 1'b1, 16'h0100, 1'b0, 1'b0, 2'd2, 2'd2, 3'd0, 3'd0}, // R6 ext kept
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd1, 2'd0, 3'd5, 3'd0}, // R5 read
    '{1'b0, 1'b1, 1'b1, 16'h0100, 1'b1, 1'b1, 2'd1, 2'd0, 3'd0, 3'd5}, // R5 write, R6
    '{1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd2, 2'd2, 3'd0, 3'd0}, // R1 x2 ext
    '{1'b1, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b0, 2'd2, 2'd0, 3'd0, 3'd0}, // R3 x2 int
    '{1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd1, 2'd0, 3'd5, 3'd0}, // R5 x2 read
    '{1'b1, 1'b1, 1'b0, 16'h8000, 1'b1, 1'b1, 2'd1, 2'd0, 3'd0, 3'd5}  // R5 x2 write
  };

  // Per-cycle measurements
  int m_ale, m_psen, m_rd, m_wr, m_rdy, m_lpsen, m_gap;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Wait for a cycle boundary, offer a request there, then measure one cycle.
  task automatic next_cycle(input logic want, input logic wrt);
    int mc;
    int first_rise;
    logic p_ale, p_psen, p_lpsen;
    mc = x2_en ? 6 : 12;
    do @(negedge clk); while (!movx_ready);
    movx_valid = want;
    movx_write = wrt;
    m_ale = 0; m_psen = 0; m_rd = 0; m_wr = 0; m_rdy = 0; m_lpsen = 0; m_gap = -1;
    first_rise = -1;
    p_ale = 1'b0; p_psen = 1'b1; p_lpsen = 1'b1;
    for (int i = 0; i < mc; i++) begin
      @(negedge clk);
      if (i == 0) begin
        movx_valid = 1'b0;
        movx_write = 1'b0;
      end
      if (ale && !p_ale) begin
        m_ale++;
        if (first_rise < 0) first_rise = i;
        else m_gap = i - first_rise;
      end
      if (!psen_n && p_psen) m_psen++;
      if (!l_psen_n && p_lpsen) m_lpsen++;
      if (!rd_n) m_rd++;
      if (!wr_n) m_wr++;
      if (movx_ready) m_rdy++;
      p_ale = ale; p_psen = psen_n; p_lpsen = l_psen_n;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    report();
    $finish;
  end

  initial begin : main
    int cps;
    // Reset qualification in normal timing
    repeat (2) @(negedge clk);
    rst_in = 1'b1;
    repeat (23) @(posedge clk);
    @(negedge clk);
    chk("R8 no reset after 23 edges", int'(sys_rst), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 reset at 24th edge", int'(sys_rst), 1);
    chk("R9 ale low in reset", int'(ale), 0);
    chk("R9 strobes high in reset", int'({psen_n, rd_n, wr_n}), 7);
    chk("R9 ready low in reset", int'(movx_ready), 0);
    rst_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 release on first low edge", int'(sys_rst), 0);
    chk("R9 first clock is S0 with ale", int'(ale), 1);

    // Table of vectors
    for (int v = 0; v < NV; v++) begin
      x2_en   = VECS[v].x2;
      ea_in   = VECS[v].ea;
      ale_dis = VECS[v].aoff;
      pc      = VECS[v].pc;
      cps     = VECS[v].x2 ? 1 : 2;
      next_cycle(VECS[v].mv, VECS[v].wr);
      chk($sformatf("R1/R5/R6 ale pulses v%0d", v), m_ale, int'(VECS[v].e_ale));
      chk($sformatf("R2/R3/R4 psen pulses v%0d", v), m_psen, int'(VECS[v].e_psen));
      chk($sformatf("R5 rd clocks v%0d", v), m_rd, int'(VECS[v].e_rd) * cps);
      chk($sformatf("R5 wr clocks v%0d", v), m_wr, int'(VECS[v].e_wr) * cps);
      chk($sformatf("R7 ready clocks v%0d", v), m_rdy, 1);
      if (VECS[v].e_ale == 2'd2)
        chk($sformatf("R1 ale spacing v%0d", v), m_gap, 3 * cps);
    end

    // R7: valid outside the ready clock is ignored
    x2_en = 1'b0; ea_in = 1'b0; ale_dis = 1'b0; pc = 16'h0000;
    do @(negedge clk); while (!movx_ready);
    @(negedge clk);
    movx_valid = 1'b1;
    movx_write = 1'b0;
    repeat (3) @(negedge clk);
    movx_valid = 1'b0;
    next_cycle(1'b0, 1'b0);
    chk("R7 stray valid: psen pulses", m_psen, 2);
    chk("R7 stray valid: rd clocks", m_rd, 0);

    // Reset qualification in double-speed timing, EA high during reset
    @(negedge clk);
    x2_en = 1'b1;
    ea_in = 1'b1;
    rst_in = 1'b1;
    repeat (11) @(posedge clk);
    @(negedge clk);
    chk("R8 x2 no reset after 11 edges", int'(sys_rst), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 x2 reset at 12th edge", int'(sys_rst), 1);
    rst_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ea_in = 1'b0;
    pc = 16'h0000;
    next_cycle(1'b0, 1'b0);
    chk("R4 live EA low goes external", m_psen, 2);
    chk("R10 locked EA ignores later low", m_lpsen, 0);

    report();
    $finish;
  end
endmodule